// File: doc/BRIEF.md
# Super I/O Configuration Controller

This block is the configuration register unit of a multi-function peripheral controller. It is reached through a window of two byte ports on an 8-bit host I/O bus: an index port and, one address above it, a data port. After reset the block is locked and invisible. Every access passes by it until the host writes the unlock key to the index port.

While unlocked, the host writes a register index to the index port. It then reads or writes that register through the data port. One register holds a device selector. This selector picks which of nine per-device banks the device-specific indices reach. Each bank holds an activate flag, a 16-bit I/O base, an interrupt routing byte and a DMA routing byte. Three global registers hold a power-control byte and the settings of two general-purpose pins. Writing the lock key to the index port closes the window again.

The block drives out every device's decoded base, enable, interrupt and DMA routing continuously, so the peripheral decoders around it need no bus access of their own. The peripheral functions themselves live elsewhere.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: After reset the block is locked (`cfg_mode_o`=0), `io_rdata_oe`=0, `io_rdata`=0x00, the selected device is 0 and every `dev_en_o` bit is 0.
- R2: A write of 0x55 to the index port (address 0x3F0) while locked unlocks the block on the next clock. A write of 0xAA to the index port while unlocked locks it on the next clock.
- R3: While locked, a write of any value other than 0x55 to the index port leaves the block locked. No series of such writes brings it closer to unlocking.
- R4: While locked, writes to the data port (address 0x3F1) change nothing, and no read drives the bus: `io_rdata_oe`=0 and `io_rdata`=0x00.
- R5: While unlocked, a write of any value except 0xAA to the index port selects that index. A read of the index port returns the selected index with `io_rdata_oe`=1 in the same cycle. Unlocking selects index 0x00.
- R6: Index 0x07 holds the selected device number. Values 0 to 8 are accepted; a value above 8 is ignored and the previous selection is kept. The device numbers are: 0 floppy, 1 first disk, 2 second disk, 3 printer, 4 first serial, 5 second serial, 6 clock, 7 keyboard, 8 auxiliary.
- R7: The following indices reach the selected device only. Index 0x30 is the activate flag: bit 0 is stored, and a read returns 0x00 or 0x01. Indices 0x60 and 0x61 are the high and low bytes of the base. Index 0x70 is the interrupt select and index 0x74 is the DMA select.
- R8: Device d drives its base on `dev_base_o[16*d +: 16]`, its interrupt select on `dev_irq_o[8*d +: 8]` and its DMA select on `dev_dma_o[8*d +: 8]`. `dev_en_o[d]` is its activate flag ANDed with a nonzero base.
- R9: Index 0x22 is the power-control byte and drives `pwr_ctrl_o`. Indices 0xC6 and 0xC7 drive `gpio_a_cfg_o` and `gpio_b_cfg_o`. All three read back their value and reset to 0x00.
- R10: A read of any other index returns 0x00, and a write to it changes no output.
- R11: Data reads are combinational in the cycle the read strobe is high. A register write is visible at the outputs after the clock edge that samples the write strobe.
- R12: The reset bases for devices 0 to 8 are 0x3F0, 0x1F0, 0x170, 0x378, 0x2F8, 0x3F8, 0x070, 0x060 and 0x000. The interrupt and DMA selects reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data, 0x00 when not driven |
| io_rdata_oe | output | 1 | Read data is being driven |
| cfg_mode_o | output | 1 | Configuration window is unlocked |
| dev_base_o | output | 144 | Per-device I/O base, 16 bits per device |
| dev_en_o | output | 9 | Per-device decoded enable |
| dev_irq_o | output | 72 | Per-device interrupt select, 8 bits per device |
| dev_dma_o | output | 72 | Per-device DMA select, 8 bits per device |
| pwr_ctrl_o | output | 8 | Global power-control byte |
| gpio_a_cfg_o | output | 8 | First general-purpose pin configuration |
| gpio_b_cfg_o | output | 8 | Second general-purpose pin configuration |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle, and that every strobe and its address and data are stable across the sampling edge. Under these assumptions, a lock-state change can only come from a strobed write to the index port, and bank state can only move while unlocked. The bench keeps to these rules: it changes all bus inputs at the falling edge, raises exactly one strobe per access, and drops it before the next access. Out-of-range device numbers, non-key index writes while locked, and unassigned indices are driven on purpose, since they are legal bus traffic that the block must absorb.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned BASE_W = 16;
  localparam int unsigned NUM_DEV = 9;

  localparam logic [REG_W-1:0] KEY_OPEN  = 8'h55;
  localparam logic [REG_W-1:0] KEY_CLOSE = 8'hAA;

  // register indices; the host software decodes these values
  localparam logic [REG_W-1:0] IX_DEVSEL  = 8'h07;
  localparam logic [REG_W-1:0] IX_POWER   = 8'h22;
  localparam logic [REG_W-1:0] IX_ACTIVE  = 8'h30;
  localparam logic [REG_W-1:0] IX_BASE_HI = 8'h60;
  localparam logic [REG_W-1:0] IX_BASE_LO = 8'h61;
  localparam logic [REG_W-1:0] IX_IRQ     = 8'h70;
  localparam logic [REG_W-1:0] IX_DMA     = 8'h74;
  localparam logic [REG_W-1:0] IX_PIN_A   = 8'hC6;
  localparam logic [REG_W-1:0] IX_PIN_B   = 8'hC7;

  // bank register kinds, decoded from the index
  typedef enum logic [2:0] {
    BK_NONE,
    BK_ACTIVE,
    BK_BASE_HI,
    BK_BASE_LO,
    BK_IRQ,
    BK_DMA
  } bank_reg_e;

  function automatic bank_reg_e bank_reg_of(input logic [REG_W-1:0] ix);
    bank_reg_e r;
    case (ix)
      IX_ACTIVE:  r = BK_ACTIVE;
      IX_BASE_HI: r = BK_BASE_HI;
      IX_BASE_LO: r = BK_BASE_LO;
      IX_IRQ:     r = BK_IRQ;
      IX_DMA:     r = BK_DMA;
      default:    r = BK_NONE;
    endcase
    return r;
  endfunction

  // reset base per device number
  function automatic logic [BASE_W-1:0] reset_base(input int unsigned dev);
    logic [BASE_W-1:0] b;
    case (dev)
      0:       b = 16'h03F0;
      1:       b = 16'h01F0;
      2:       b = 16'h0170;
      3:       b = 16'h0378;
      4:       b = 16'h02F8;
      5:       b = 16'h03F8;
      6:       b = 16'h0070;
      7:       b = 16'h0060;
      default: b = 16'h0000;
    endcase
    return b;
  endfunction

  // a device decodes only when active and placed at a nonzero base
  function automatic logic decode_enable(input logic active,
                                         input logic [BASE_W-1:0] base);
    return active && (base != '0);
  endfunction

endpackage

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [REG_W-1:0]  io_wdata,
  output logic              open_q,
  output logic [REG_W-1:0]  index_q,
  output logic              data_wr_evt,
  output logic              data_rd_evt,
  output logic              index_rd_evt,
  output logic              open_evt,
  output logic              close_evt
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = WIN_ADDR + ADDR_W'(1);

  logic hit_index;
  logic hit_data;
  logic index_wr_evt;

  assign hit_index = (io_addr == WIN_ADDR);
  assign hit_data  = (io_addr == DATA_ADDR);

  assign open_evt     = !open_q && io_wr && hit_index && (io_wdata == KEY_OPEN);
  assign close_evt    =  open_q && io_wr && hit_index && (io_wdata == KEY_CLOSE);
  assign index_wr_evt =  open_q && io_wr && hit_index && (io_wdata != KEY_CLOSE);
  assign data_wr_evt  =  open_q && io_wr && hit_data;
  assign data_rd_evt  =  open_q && io_rd && hit_data;
  assign index_rd_evt =  open_q && io_rd && hit_index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      index_q <= '0;
    end else begin
      if (open_evt) begin
        open_q  <= 1'b1;
        index_q <= '0;
      end else if (close_evt) begin
        open_q  <= 1'b0;
      end else if (index_wr_evt) begin
        index_q <= io_wdata;
      end
    end
  end

endmodule

// File: rtl/sio_cfg_global.sv
module sio_cfg_global
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NDEV  = NUM_DEV,
  parameter int unsigned SEL_W = $clog2(NDEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic [REG_W-1:0] index,
  input  logic [REG_W-1:0] wdata,
  output logic [SEL_W-1:0] devsel_q,
  output logic [REG_W-1:0] power_q,
  output logic [REG_W-1:0] pin_a_q,
  output logic [REG_W-1:0] pin_b_q
);

  logic sel_ok;
  assign sel_ok = (wdata < REG_W'(NDEV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devsel_q <= '0;
      power_q  <= '0;
      pin_a_q  <= '0;
      pin_b_q  <= '0;
    end else if (wr_evt) begin
      case (index)
        IX_DEVSEL: if (sel_ok) devsel_q <= wdata[SEL_W-1:0];
        IX_POWER:  power_q <= wdata;
        IX_PIN_A:  pin_a_q <= wdata;
        IX_PIN_B:  pin_b_q <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [BASE_W-1:0] RST_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  index,
  input  logic [REG_W-1:0]  wdata,
  output logic              active_q,
  output logic [BASE_W-1:0] base_q,
  output logic [REG_W-1:0]  irq_q,
  output logic [REG_W-1:0]  dma_q,
  output logic              enable
);

  bank_reg_e kind;
  assign kind = bank_reg_of(index);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= RST_BASE;
      irq_q    <= '0;
      dma_q    <= '0;
    end else if (wr_en) begin
      case (kind)
        BK_ACTIVE:  active_q     <= wdata[0];
        BK_BASE_HI: base_q[15:8] <= wdata;
        BK_BASE_LO: base_q[7:0]  <= wdata;
        BK_IRQ:     irq_q        <= wdata;
        BK_DMA:     dma_q        <= wdata;
        default: ;
      endcase
    end
  end

  assign enable = decode_enable(active_q, base_q);

endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 16'h03F0,
  parameter int unsigned NDEV = NUM_DEV
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [REG_W-1:0]         io_wdata,
  output logic [REG_W-1:0]         io_rdata,
  output logic                     io_rdata_oe,
  output logic                     cfg_mode_o,
  output logic [NDEV*BASE_W-1:0]   dev_base_o,
  output logic [NDEV-1:0]          dev_en_o,
  output logic [NDEV*REG_W-1:0]    dev_irq_o,
  output logic [NDEV*REG_W-1:0]    dev_dma_o,
  output logic [REG_W-1:0]         pwr_ctrl_o,
  output logic [REG_W-1:0]         gpio_a_cfg_o,
  output logic [REG_W-1:0]         gpio_b_cfg_o
);

  localparam int unsigned SEL_W = $clog2(NDEV);

  // named internal events, also observed by the checker
  logic              open_q;
  logic [REG_W-1:0]  index_q;
  logic              data_wr_evt;
  logic              data_rd_evt;
  logic              index_rd_evt;
  logic              open_evt;
  logic              close_evt;
  logic [SEL_W-1:0]  devsel_q;

  logic [NDEV-1:0]             active_all;
  logic [NDEV-1:0][BASE_W-1:0] base_all;
  logic [NDEV-1:0][REG_W-1:0]  irq_all;
  logic [NDEV-1:0][REG_W-1:0]  dma_all;

  sio_cfg_port #(
    .ADDR_W  (ADDR_W),
    .WIN_ADDR(WIN_ADDR)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_wdata    (io_wdata),
    .open_q      (open_q),
    .index_q     (index_q),
    .data_wr_evt (data_wr_evt),
    .data_rd_evt (data_rd_evt),
    .index_rd_evt(index_rd_evt),
    .open_evt    (open_evt),
    .close_evt   (close_evt)
  );

  sio_cfg_global #(
    .NDEV (NDEV),
    .SEL_W(SEL_W)
  ) u_global (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_evt  (data_wr_evt),
    .index   (index_q),
    .wdata   (io_wdata),
    .devsel_q(devsel_q),
    .power_q (pwr_ctrl_o),
    .pin_a_q (gpio_a_cfg_o),
    .pin_b_q (gpio_b_cfg_o)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_bank
    logic bank_wr;
    assign bank_wr = data_wr_evt && (devsel_q == SEL_W'(d));

    sio_cfg_bank #(
      .RST_BASE(reset_base(d))
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .index   (index_q),
      .wdata   (io_wdata),
      .active_q(active_all[d]),
      .base_q  (base_all[d]),
      .irq_q   (irq_all[d]),
      .dma_q   (dma_all[d]),
      .enable  (dev_en_o[d])
    );

    assign dev_base_o[d*BASE_W +: BASE_W] = base_all[d];
    assign dev_irq_o[d*REG_W +: REG_W]    = irq_all[d];
    assign dev_dma_o[d*REG_W +: REG_W]    = dma_all[d];
  end

  // read-back of the register at the selected index
  logic [REG_W-1:0] reg_view;
  always_comb begin
    case (index_q)
      IX_DEVSEL:  reg_view = REG_W'(devsel_q);
      IX_POWER:   reg_view = pwr_ctrl_o;
      IX_PIN_A:   reg_view = gpio_a_cfg_o;
      IX_PIN_B:   reg_view = gpio_b_cfg_o;
      IX_ACTIVE:  reg_view = {{(REG_W-1){1'b0}}, active_all[devsel_q]};
      IX_BASE_HI: reg_view = base_all[devsel_q][15:8];
      IX_BASE_LO: reg_view = base_all[devsel_q][7:0];
      IX_IRQ:     reg_view = irq_all[devsel_q];
      IX_DMA:     reg_view = dma_all[devsel_q];
      default:    reg_view = '0;
    endcase
  end

  always_comb begin
    io_rdata = '0;
    if (data_rd_evt)       io_rdata = reg_view;
    else if (index_rd_evt) io_rdata = index_q;
  end

  assign io_rdata_oe = data_rd_evt || index_rd_evt;
  assign cfg_mode_o  = open_q;

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_ADDR = 16'h03F0,
  parameter int unsigned NDEV = NUM_DEV,
  parameter int unsigned SEL_W = $clog2(NDEV)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      io_addr,
  input logic                   io_wr,
  input logic [REG_W-1:0]       io_wdata,
  input logic                   io_rdata_oe,
  input logic [REG_W-1:0]       io_rdata,
  input logic                   cfg_mode_o,
  input logic                   data_wr_evt,
  input logic [SEL_W-1:0]       devsel_q,
  input logic [NDEV*BASE_W-1:0] dev_base_o,
  input logic [NDEV-1:0]        dev_en_o
);

  logic idx_wr;
  assign idx_wr = io_wr && (io_addr == WIN_ADDR);

  p_open_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode_o && idx_wr && io_wdata == KEY_OPEN) |=> cfg_mode_o);

  p_close_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode_o && idx_wr && io_wdata == KEY_CLOSE) |=> !cfg_mode_o);

  p_locked_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode_o && !(idx_wr && io_wdata == KEY_OPEN)) |=> !cfg_mode_o);

  p_locked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode_o |-> (!io_rdata_oe && io_rdata == '0 && !data_wr_evt));

  p_locked_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode_o |=> $stable(dev_base_o));

  p_devsel_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    devsel_q < SEL_W'(NDEV));

  for (genvar g = 0; g < NDEV; g++) begin : g_en_chk
    p_en_needs_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dev_en_o[g] |-> (dev_base_o[g*BASE_W +: BASE_W] != '0));
  end

endmodule

bind sio_cfg_ctrl sio_cfg_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_ADDR(WIN_ADDR),
  .NDEV    (NDEV),
  .SEL_W   (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .io_rdata_oe(io_rdata_oe),
  .io_rdata   (io_rdata),
  .cfg_mode_o (cfg_mode_o),
  .data_wr_evt(data_wr_evt),
  .devsel_q   (devsel_q),
  .dev_base_o (dev_base_o),
  .dev_en_o   (dev_en_o)
);

// File: tb/test_sio_cfg_ctrl.sv
module test_sio_cfg_ctrl;

  localparam int ND = 9;
  localparam logic [15:0] PIX = 16'h03F0;
  localparam logic [15:0] PDT = 16'h03F1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   io_addr = '0;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic          io_rdata_oe;
  logic          cfg_mode_o;
  logic [ND*16-1:0] dev_base_o;
  logic [ND-1:0] dev_en_o;
  logic [ND*8-1:0] dev_irq_o;
  logic [ND*8-1:0] dev_dma_o;
  logic [7:0]    pwr_ctrl_o;
  logic [7:0]    gpio_a_cfg_o;
  logic [7:0]    gpio_b_cfg_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sio_cfg_ctrl i_sio_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
    .cfg_mode_o(cfg_mode_o), .dev_base_o(dev_base_o), .dev_en_o(dev_en_o),
    .dev_irq_o(dev_irq_o), .dev_dma_o(dev_dma_o), .pwr_ctrl_o(pwr_ctrl_o),
    .gpio_a_cfg_o(gpio_a_cfg_o), .gpio_b_cfg_o(gpio_b_cfg_o)
  );

  function automatic logic [15:0] exp_base0(input int d);
    logic [15:0] t [ND] = '{16'h03F0, 16'h01F0, 16'h0170, 16'h0378, 16'h02F8,
                            16'h03F8, 16'h0070, 16'h0060, 16'h0000};
    return t[d];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    v = io_rdata; oe = io_rdata_oe;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] v);
    wr(PIX, ix);
    wr(PDT, v);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] v, output logic oe);
    wr(PIX, ix);
    rd(PDT, v, oe);
  endtask

  task automatic t_reset();
    logic [7:0] v; logic oe;
    chk("R1 mode", cfg_mode_o, 0);
    chk("R1 enables", dev_en_o, 0);
    for (int d = 0; d < ND; d++) begin
      chk("R12 base", dev_base_o[16*d +: 16], exp_base0(d));
      chk("R12 irq", dev_irq_o[8*d +: 8], 0);
    end
    rd(PDT, v, oe);
    chk("R1 oe", oe, 0);
    chk("R1 rdata", v, 0);
  endtask

  task automatic t_locked();
    logic [7:0] v; logic oe;
    wr(PDT, 8'h60);
    wr(PIX, 8'h60);
    wr(PDT, 8'h12);
    chk("R4 base unchanged", dev_base_o[15:0], 16'h03F0);
    rd(PIX, v, oe);
    chk("R4 index read oe", oe, 0);
    chk("R4 index read data", v, 0);
    wr(PIX, 8'hAA); wr(PIX, 8'h54); wr(PIX, 8'h56); wr(PIX, 8'h00);
    chk("R3 still locked", cfg_mode_o, 0);
    wr(PDT, 8'h01);
    chk("R3 no effect", dev_base_o[15:0], 16'h03F0);
  endtask

  task automatic t_unlock();
    logic [7:0] v; logic oe;
    wr(PIX, 8'h55);
    chk("R2 unlocked", cfg_mode_o, 1);
    rd(PIX, v, oe);
    chk("R5 index after unlock", v, 8'h00);
    chk("R5 index oe", oe, 1);
    wr(PIX, 8'hC6);
    rd(PIX, v, oe);
    chk("R5 index select", v, 8'hC6);
    wr(PIX, 8'h55);
    rd(PIX, v, oe);
    chk("R5 key as index", {cfg_mode_o, v}, {1'b1, 8'h55});
  endtask

  task automatic t_devsel();
    logic [7:0] v; logic oe;
    reg_rd(8'h07, v, oe);
    chk("R6 devsel reset", v, 0);
    reg_wr(8'h07, 8'h05);
    rd(PDT, v, oe);
    chk("R6 devsel 5", v, 5);
    reg_wr(8'h07, 8'h09);
    rd(PDT, v, oe);
    chk("R6 devsel 9 ignored", v, 5);
    reg_wr(8'h07, 8'h08);
    rd(PDT, v, oe);
    chk("R6 devsel 8", v, 8);
    reg_wr(8'h07, 8'hFF);
    rd(PDT, v, oe);
    chk("R6 devsel FF ignored", v, 8);
  endtask

  task automatic t_bank();
    logic [7:0] v; logic oe;
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h60, 8'h12);
    chk("R11 hi byte after edge", dev_base_o[16*4 +: 16], 16'h12F8);
    reg_wr(8'h61, 8'h34);
    reg_wr(8'h70, 8'h04);
    reg_wr(8'h74, 8'h02);
    chk("R7 base", dev_base_o[16*4 +: 16], 16'h1234);
    chk("R8 irq", dev_irq_o[8*4 +: 8], 8'h04);
    chk("R8 dma", dev_dma_o[8*4 +: 8], 8'h02);
    chk("R8 not active yet", dev_en_o, 0);
    reg_wr(8'h30, 8'hFF);
    chk("R8 enable", dev_en_o, 9'h010);
    rd(PDT, v, oe);
    chk("R7 active reads 01", v, 8'h01);
    reg_rd(8'h60, v, oe);
    chk("R7 base hi read", v, 8'h12);
    reg_rd(8'h74, v, oe);
    chk("R11 dma read", {oe, v}, {1'b1, 8'h02});
    chk("R7 neighbour base", dev_base_o[16*5 +: 16], 16'h03F8);
    chk("R7 neighbour irq", dev_irq_o[8*3 +: 8], 8'h00);
  endtask

  task automatic t_zero_base();
    logic [7:0] v; logic oe;
    reg_wr(8'h07, 8'h08);
    reg_wr(8'h30, 8'h01);
    chk("R8 zero base no enable", dev_en_o[8], 0);
    reg_wr(8'h61, 8'h80);
    chk("R8 nonzero base enables", dev_en_o[8], 1);
    reg_wr(8'h30, 8'h02);
    chk("R8 bit0 clear disables", dev_en_o[8], 0);
    reg_rd(8'h30, v, oe);
    chk("R7 active reads 00", v, 8'h00);
  endtask

  task automatic t_global();
    logic [7:0] v; logic oe;
    chk("R9 reset", {pwr_ctrl_o, gpio_a_cfg_o, gpio_b_cfg_o}, 0);
    reg_wr(8'h22, 8'hA5);
    reg_wr(8'hC6, 8'h3C);
    reg_wr(8'hC7, 8'h81);
    chk("R9 outputs", {pwr_ctrl_o, gpio_a_cfg_o, gpio_b_cfg_o}, 24'hA53C81);
    reg_rd(8'hC7, v, oe);
    chk("R9 read C7", v, 8'h81);
    reg_wr(8'h23, 8'h77);
    rd(PDT, v, oe);
    chk("R10 unassigned read", {oe, v}, {1'b1, 8'h00});
    chk("R10 write no effect", {pwr_ctrl_o, gpio_a_cfg_o, gpio_b_cfg_o}, 24'hA53C81);
    chk("R10 bank no effect", dev_base_o[16*8 +: 16], 16'h0080);
  endtask

  task automatic t_relock();
    logic [7:0] v; logic oe;
    wr(PIX, 8'h61);
    wr(PIX, 8'hAA);
    chk("R2 relocked", cfg_mode_o, 0);
    wr(PDT, 8'h00);
    chk("R4 write after relock", dev_base_o[16*8 +: 16], 16'h0080);
    rd(PDT, v, oe);
    chk("R4 read after relock", {oe, v}, 0);
    wr(PIX, 8'h55);
    rd(PIX, v, oe);
    chk("R5 index cleared on reopen", {cfg_mode_o, v}, {1'b1, 8'h00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_devsel();
    t_bank();
    t_zero_base();
    t_global();
    t_relock();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule